// File: doc/BRIEF.md
# ADC Trigger Collision Error Detector

This block sits between the trigger sources of an A/D converter and its conversion sequencer. It takes any number of asynchronous start-trigger pins and the same number of asynchronous load-trigger pins, with two of each by default. It brings every pin into the converter clock domain and turns each rising edge into a single-cycle event. When a start event arrives while the converter reports idle, the block issues a one-cycle conversion start and reports which path caused it.

When a start event arrives while a conversion is running, the event is dropped. In the extended error mode, the dropped event sets a buffered error flag for that path. The matching load trigger later copies the buffered flag into a visible error flag. Software can clear the buffered and visible flags separately through per-path clear pulses.

After a start is accepted, a short mask window keeps a bounce or repeat of the same trigger from counting as a collision. The converter core, channel selection and result storage are outside this block.

Top module: `adc_trig_guard`

## Requirements
- R1: Each trigger pin passes through a two-flop synchronizer and a rising-edge detector. A pin that rises before clock edge k acts on the outputs at edge k+2, which is the third rising edge that samples it high. A pin held high produces no further event.
- R2: A start event on a path that is not masked, arriving while conv_busy_i is low, makes conv_start_o high for one cycle. In that cycle start_sel_o is one-hot: bit i set means path i started. When no start is issued, start_sel_o is 0.
- R3: A start event that is not masked and arrives while conv_busy_i is high issues no start. With ext_mode_i high, it sets bit i of err_buf_o.
- R4: A load event on path i copies the current (pre-update) value of err_buf_o[i] into err_vis_o[i], including a copy of 0. It takes priority over clr_vis_i[i] in the same cycle. err_vis_o changes only on a load event or a visible-flag clear.
- R5: When several paths request a start in the same idle cycle, the lowest index wins (path 1 is bit 0). Each losing path is treated as a collision and, in extended mode, sets its bit of err_buf_o.
- R6: With ext_mode_i low, no bit of err_buf_o is ever set. Starts are still issued and busy collisions are still dropped.
- R7: After a start is accepted on a path, any start event on that path in the following 3 clock cycles is ignored. Such an event issues no start and sets no flag. An event after the window is handled normally.
- R8: A high clr_buf_i[i] clears err_buf_o[i] at the next edge, and a high clr_vis_i[i] clears err_vis_o[i]. If a collision sets err_buf_o[i] in the same cycle as its clear, the set wins.
- R9: While rst_ni is low, conv_start_o, start_sel_o, err_buf_o and err_vis_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_trig_i | input | N_PATHS | Asynchronous start-trigger pins, bit 0 = path 1 |
| load_trig_i | input | N_PATHS | Asynchronous load-trigger pins, one per path |
| ext_mode_i | input | 1 | Extended mode, enables error-flag setting |
| conv_busy_i | input | 1 | Converter reports conversion in progress |
| clr_buf_i | input | N_PATHS | Synchronous clear pulses for buffered flags |
| clr_vis_i | input | N_PATHS | Synchronous clear pulses for visible flags |
| conv_start_o | output | 1 | One-cycle conversion start |
| start_sel_o | output | N_PATHS | One-hot source of the current start |
| err_buf_o | output | N_PATHS | Buffered collision flags |
| err_vis_o | output | N_PATHS | Visible collision flags |

## Verification
The hardest case to reach from the ports is a retrigger that lands inside the mask window. A second rising edge has to reach the synchronizer output while the counter is still running, and the converter must already report busy. Otherwise a missing mask looks the same as a plain start or a plain collision.

The directed test pulses the pin for one cycle and raises it again two cycles later. Busy is raised only after the first start has been issued, so the repeat event falls in the second masked cycle with busy high. A later, unmasked retrigger with busy high then confirms that the window has closed.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned N_PATHS_DEF     = 2;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  // 2.5 converter clocks rounded up to whole cycles
  localparam int unsigned MASK_CYCLES_DEF = 3;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign pulse_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate #(
  parameter int unsigned MASK_CYCLES = 3,
  localparam int unsigned CW = $clog2(MASK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic busy_i,
  input  logic grant_i,
  output logic live_o,
  output logic want_o,
  output logic masked_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (grant_i)       cnt_q <= CW'(MASK_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign masked_o = (cnt_q != '0);
  assign live_o   = pulse_i & ~masked_o;
  assign want_o   = live_o & ~busy_i;

  assert_grant_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> (!busy_i && pulse_i));
  assert_mask_loaded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> masked_o);
endmodule

// File: rtl/adc_err_flags.sv
module adc_err_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_buf_i,
  input  logic load_i,
  input  logic clr_vis_i,
  output logic buf_o,
  output logic vis_o
);
  logic buf_q, vis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= 1'b0;
      vis_q <= 1'b0;
    end else begin
      if (set_i)          buf_q <= 1'b1;
      else if (clr_buf_i) buf_q <= 1'b0;
      if (load_i)         vis_q <= buf_q;
      else if (clr_vis_i) vis_q <= 1'b0;
    end
  end

  assign buf_o = buf_q;
  assign vis_o = vis_q;

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> buf_q);
  assert_load_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (vis_q == $past(buf_q)));
endmodule

// File: rtl/adc_trig_guard.sv
module adc_trig_guard
  import adc_trig_pkg::*;
#(
  parameter int unsigned N_PATHS     = N_PATHS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned MASK_CYCLES = MASK_CYCLES_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PATHS-1:0] start_trig_i,
  input  logic [N_PATHS-1:0] load_trig_i,
  input  logic               ext_mode_i,
  input  logic               conv_busy_i,
  input  logic [N_PATHS-1:0] clr_buf_i,
  input  logic [N_PATHS-1:0] clr_vis_i,
  output logic               conv_start_o,
  output logic [N_PATHS-1:0] start_sel_o,
  output logic [N_PATHS-1:0] err_buf_o,
  output logic [N_PATHS-1:0] err_vis_o
);
  logic [N_PATHS-1:0] st_pulse, ld_pulse, live, want, masked, grant, set_buf;
  logic [N_PATHS-1:0] sel_q;
  logic               start_q;

  for (genvar i = 0; i < N_PATHS; i++) begin : g_path
    adc_trig_sync #(.STAGES(SYNC_STAGES)) u_st_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(start_trig_i[i]), .pulse_o(st_pulse[i])
    );
    adc_trig_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(load_trig_i[i]), .pulse_o(ld_pulse[i])
    );
    adc_trig_gate #(.MASK_CYCLES(MASK_CYCLES)) u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(st_pulse[i]), .busy_i(conv_busy_i),
      .grant_i(grant[i]), .live_o(live[i]), .want_o(want[i]), .masked_o(masked[i])
    );
    adc_err_flags u_flags (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_buf[i]), .clr_buf_i(clr_buf_i[i]),
      .load_i(ld_pulse[i]), .clr_vis_i(clr_vis_i[i]),
      .buf_o(err_buf_o[i]), .vis_o(err_vis_o[i])
    );

    assert_mask_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      masked[i] |=> !($rose(err_buf_o[i]) || start_sel_o[i]));
    assert_mode_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_buf_o[i]) |-> $past(ext_mode_i));
    assert_vis_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(err_vis_o[i]) |-> $past(ld_pulse[i] || clr_vis_i[i]));
  end

  // lowest index wins; losers fall through to collision
  assign grant   = want & (~want + 1'b1);
  assign set_buf = (live & ~grant) & {N_PATHS{ext_mode_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      start_q <= 1'b0;
    end else begin
      sel_q   <= grant;
      start_q <= |grant;
    end
  end

  assign start_sel_o  = sel_q;
  assign conv_start_o = start_q;

  assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> $past(!conv_busy_i));
  assert_sel_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_sel_o) && (conv_start_o == (start_sel_o != '0)));
  assert_start_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
endmodule

// File: tb/adc_trig_guard_tb_top.sv
module adc_trig_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic       clk_i = 0, rst_ni = 0;
  logic [1:0] start_trig_i = 0, load_trig_i = 0, clr_buf_i = 0, clr_vis_i = 0;
  logic       ext_mode_i = 1, conv_busy_i = 0;
  logic       conv_start_o;
  logic [1:0] start_sel_o, err_buf_o, err_vis_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_trig_guard dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_trig_i(start_trig_i), .load_trig_i(load_trig_i),
    .ext_mode_i(ext_mode_i), .conv_busy_i(conv_busy_i), .clr_buf_i(clr_buf_i),
    .clr_vis_i(clr_vis_i), .conv_start_o(conv_start_o), .start_sel_o(start_sel_o),
    .err_buf_o(err_buf_o), .err_vis_o(err_vis_o)
  );

  // {start, load, busy, mode, clr_buf, clr_vis | exp_sel, exp_buf, exp_vis}
  localparam logic [15:0] VEC [NV] = '{
    16'b01_00_0_1_00_00_01_00_00, // R2 idle start path 1
    16'b01_00_1_1_00_00_00_01_00, // R3 busy collision path 1
    16'b10_00_1_1_00_00_00_11_00, // R3 busy collision path 2
    16'b00_01_0_1_00_00_00_11_01, // R4 load path 1
    16'b00_00_0_1_10_00_00_01_01, // R8 clear buffered path 2
    16'b11_00_0_1_00_00_01_11_01, // R5 both idle, path 1 wins
    16'b00_10_0_1_11_00_00_00_11, // R4 load sees pre-clear value
    16'b00_00_0_1_00_01_00_00_10, // R8 clear visible path 1
    16'b10_00_1_0_00_00_00_00_10, // R6 mode off, no flag
    16'b10_00_0_0_00_00_10_00_10, // R6 mode off, start works
    16'b01_00_1_1_01_00_00_01_10, // R8 set beats clear
    16'b00_11_0_1_00_00_00_01_01, // R4 load copies 1 and 0
    16'b00_01_0_1_00_01_00_01_01  // R4 load beats visible clear
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic apply_vec(input logic [15:0] v);
    @(negedge clk_i);
    start_trig_i = v[15:14]; load_trig_i = v[13:12];
    conv_busy_i = v[11]; ext_mode_i = v[10];
    @(negedge clk_i);
    @(negedge clk_i);
    clr_buf_i = v[9:8]; clr_vis_i = v[7:6];
    @(negedge clk_i);
    clr_buf_i = 0; clr_vis_i = 0;
    check("R2,R5 start_sel", {6'b0, start_sel_o}, {6'b0, v[5:4]});
    check("R2 conv_start", {7'b0, conv_start_o}, {7'b0, |v[5:4]});
    check("R3,R5,R6,R8 err_buf", {6'b0, err_buf_o}, {6'b0, v[3:2]});
    check("R4,R8 err_vis", {6'b0, err_vis_o}, {6'b0, v[1:0]});
    start_trig_i = 0; load_trig_i = 0; conv_busy_i = 0;
    settle(6);
  endtask

  initial begin
    int starts;
    settle(2);
    check("R9 reset start", {6'b0, conv_start_o, 1'b0}, 8'h0);
    check("R9 reset flags", {2'b0, start_sel_o, err_buf_o, err_vis_o}, 8'h0);
    start_trig_i = 2'b11; load_trig_i = 2'b11;
    settle(3);
    check("R9 held in reset", {1'b0, conv_start_o, start_sel_o, err_buf_o, err_vis_o}, 8'h0);
    start_trig_i = 0; load_trig_i = 0;
    settle(4);
    rst_ni = 1;
    settle(4);

    for (int i = 0; i < NV; i++) apply_vec(VEC[i]);

    // clear everything
    clr_buf_i = 2'b11; clr_vis_i = 2'b11;
    settle(1);
    clr_buf_i = 0; clr_vis_i = 0; ext_mode_i = 1;
    settle(2);
    check("R8 all cleared", {4'b0, err_buf_o, err_vis_o}, 8'h0);

    // R1 latency and held pin
    start_trig_i[1] = 1;
    settle(1);
    check("R1 no start after 1 edge", {7'b0, conv_start_o}, 8'h0);
    settle(1);
    check("R1 no start after 2 edges", {7'b0, conv_start_o}, 8'h0);
    settle(1);
    check("R1 start after 3 edges", {6'b0, start_sel_o}, 8'h2);
    starts = 0;
    for (int c = 0; c < 10; c++) begin
      settle(1);
      if (conv_start_o) starts++;
    end
    check("R1 held pin single event", 8'(starts), 8'h0);
    start_trig_i = 0;
    settle(6);

    // R7 retrigger inside mask window with busy high
    start_trig_i[0] = 1;          // before edge k
    settle(1);
    start_trig_i[0] = 0;          // before k+1
    settle(1);
    start_trig_i[0] = 1;          // before k+2, second rise
    settle(1);
    check("R7 first start accepted", {6'b0, start_sel_o}, 8'h1);
    conv_busy_i = 1;              // repeat pulse lands in (k+3,k+4)
    starts = 0;
    for (int c = 0; c < 4; c++) begin
      settle(1);
      if (conv_start_o) starts++;
    end
    check("R7 masked repeat no start", 8'(starts), 8'h0);
    check("R7 masked repeat no flag", {6'b0, err_buf_o}, 8'h0);
    start_trig_i = 0;
    settle(4);
    start_trig_i[0] = 1;          // after window, busy high
    settle(3);
    check("R7 window closed, collision flagged", {6'b0, err_buf_o}, 8'h1);
    check("R3 collision no start", {7'b0, conv_start_o}, 8'h0);
    start_trig_i = 0; conv_busy_i = 0;
    settle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule